// File: doc/BRIEF.md
# Binary Duplex Sum Unit

This unit takes a 16-bit word and a bit slice of it, given by an upper index and a lower index, and returns the slice's duplex sum. It pairs the two outermost bits of the slice and adds twice their AND. It then moves both ends one position inward and repeats. When the two ends land on the same bit, that lone middle bit is added once, not doubled. The result is a symmetric pairwise-product sum. It is not a population count.

The unit serves as a helper stage inside an iterative square root datapath. The caller presents the word and both indices with a one-cycle start strobe. The unit then handles one symmetric pair per clock. When the last pair is done it pulses a done flag for one cycle. The registered sum holds its value until the next operation completes. While an operation is running, any new start is ignored.

Top module: `duplex_sum_unit`

## Requirements
- R1: After reset, `sum_o` is 0 and `done_o` is 0.
- R2: Each accepted operation starts its accumulation from zero, so its result does not depend on any earlier operation.
- R3: Each symmetric pair (bit `hi`, bit `lo`) with `hi > lo` adds 2 when both bits are 1 and adds 0 otherwise. After the pair, `hi` goes down by one and `lo` goes up by one.
- R4: When the two indices meet on one bit, that bit is added once, undoubled.
- R5: Worked cases with the slice written most significant bit first: slice 101 gives 2, slice 1111 gives 4, slice 011110 gives 4.
- R6: If the upper index is below the lower index when start is accepted, the result is 0 and `done_o` is high in the first cycle after the start edge.
- R7: If the upper index is at or above the lower index, `done_o` is high in cycle ceil((k-j+1)/2)+1 after the start edge.
- R8: `done_o` is high for exactly one cycle per operation. `sum_o` changes only in a cycle where `done_o` is high.
- R9: A start that arrives while an operation is running is ignored. It changes neither the running result nor its timing.
- R10: The full slice k=15, j=0 of an all-ones word gives 16, and the 5-bit output holds it without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| word_i | input | 16 | Source word, captured on start |
| k_i | input | 4 | Upper slice index |
| j_i | input | 4 | Lower slice index |
| sum_o | output | 5 | Registered duplex sum |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to produce is a start strobe that arrives in the middle of a long run. The bench must show that this strobe neither reloads the word nor restarts the index walk. To reach it, the bench launches the widest slice and raises start with a different word and indices a few cycles later. It then checks that both the result and the completion time match the first request. A sweep over every (k, j) pair with random words covers odd and even slice lengths, the meeting-in-the-middle case and crossed indices. Random back-to-back operations show that a fresh accumulation starts at zero.

// File: rtl/dsum_pkg.sv
package dsum_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dsum_state_e;
endpackage

// File: rtl/dsum_ctrl.sv
module dsum_ctrl
  import dsum_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [IW-1:0] k_i,
  input  logic [IW-1:0] j_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          empty_o,
  output logic          last_o,
  output logic [IW-1:0] hi_o,
  output logic [IW-1:0] lo_o
);
  dsum_state_e state_q;
  logic [IW-1:0] hi_q, lo_q;
  logic accept;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign load_o  = accept && (k_i >= j_i);
  assign empty_o = accept && (k_i < j_i);
  assign busy_o  = (state_q == ST_RUN);
  // final step: indices meet, or they are adjacent
  assign last_o  = busy_o && ((hi_q == lo_q) ||
                   ({1'b0, hi_q} == ({1'b0, lo_q} + 1'b1)));
  assign hi_o = hi_q;
  assign lo_o = lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_RUN;
            hi_q    <= k_i;
            lo_q    <= j_i;
          end
        end
        ST_RUN: begin
          if (last_o) begin
            state_q <= ST_IDLE;
          end else begin
            hi_q <= hi_q - 1'b1;
            lo_q <= lo_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: the walk moves both ends inward by one each step
  p_idx_walk_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_o) |=> (hi_q == $past(hi_q) - 1'b1) && (lo_q == $past(lo_q) + 1'b1));

  // R3: a step never runs with crossed indices
  p_no_cross_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (hi_q >= lo_q));

  // R9: a start during a run does not end or restart it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !last_o) |=> (busy_o && hi_q == $past(hi_q) - 1'b1));
endmodule

// File: rtl/dsum_pair.sv
module dsum_pair #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] hi_i,
  input  logic [IW-1:0] lo_i,
  output logic [1:0]    addend_o
);
  logic bit_hi, bit_lo;

  assign bit_hi = word_i[hi_i];
  assign bit_lo = word_i[lo_i];

  always_comb begin
    if (hi_i == lo_i) addend_o = {1'b0, bit_hi};
    else              addend_o = {bit_hi & bit_lo, 1'b0};
  end
endmodule

// File: rtl/dsum_acc.sv
module dsum_acc #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          empty_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [W-1:0]  word_i,
  input  logic [1:0]    addend_i,
  output logic [W-1:0]  word_o,
  output logic [SW-1:0] sum_o,
  output logic          done_o
);
  logic [W-1:0]  word_q;
  logic [SW-1:0] acc_q, sum_q, acc_nxt;
  logic          done_q;

  assign acc_nxt = acc_q + {{(SW-2){1'b0}}, addend_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      acc_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        word_q <= word_i;
        acc_q  <= '0;
      end else if (step_i) begin
        acc_q <= acc_nxt;
        if (last_i) begin
          sum_q  <= acc_nxt;
          done_q <= 1'b1;
        end
      end
      if (empty_i) begin
        sum_q  <= '0;
        done_q <= 1'b1;
      end
    end
  end

  assign word_o = word_q;
  assign sum_o  = sum_q;
  assign done_o = done_q;

  // R2: every accepted operation begins from a cleared accumulator
  p_acc_cleared_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (acc_q == '0));

  // R10: the running sum never exceeds the word width
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    acc_q <= SW'(W));

  // R8: the result only moves on a completion
  p_sum_held_r8: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(sum_q));
endmodule

// File: rtl/duplex_sum_unit.sv
module duplex_sum_unit #(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [W-1:0]          word_i,
  input  logic [$clog2(W)-1:0]  k_i,
  input  logic [$clog2(W)-1:0]  j_i,
  output logic [$clog2(W):0]    sum_o,
  output logic                  done_o
);
  localparam int IW = $clog2(W);
  localparam int SW = IW + 1;

  logic          busy, load, empty, last;
  logic [IW-1:0] hi, lo;
  logic [W-1:0]  word_q;
  logic [1:0]    addend;

  dsum_ctrl #(.IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .k_i(k_i), .j_i(j_i),
    .busy_o(busy), .load_o(load), .empty_o(empty), .last_o(last),
    .hi_o(hi), .lo_o(lo)
  );

  dsum_pair #(.W(W), .IW(IW)) u_pair (
    .word_i(word_q), .hi_i(hi), .lo_i(lo), .addend_o(addend)
  );

  dsum_acc #(.W(W), .SW(SW)) u_acc (
    .clk(clk), .rst(rst), .load_i(load), .empty_i(empty), .step_i(busy),
    .last_i(last), .word_i(word_i), .addend_i(addend),
    .word_o(word_q), .sum_o(sum_o), .done_o(done_o)
  );

  // R8: completion is only flagged once the walk has ended
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy);

  // R6: crossed indices complete on the very next cycle
  p_empty_done_r6: assert property (@(posedge clk) disable iff (rst)
    empty |=> (done_o && sum_o == '0));
endmodule

// File: tb/test_duplex_sum_unit.sv
module test_duplex_sum_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [3:0]  k_i = '0;
  logic [3:0]  j_i = '0;
  logic [4:0]  sum_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int seed_tmp;

  always #2 clk = ~clk;

  duplex_sum_unit i_duplex_sum_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
    .k_i(k_i), .j_i(j_i), .sum_o(sum_o), .done_o(done_o)
  );

  function automatic int ref_sum(input logic [15:0] w, input int k, input int j);
    int s = 0;
    int a = k;
    int b = j;
    while (a > b) begin
      s += 2 * (w[a] & w[b]);
      a--;
      b++;
    end
    if (a == b) s += w[a];
    return s;
  endfunction

  function automatic int ref_lat(input int k, input int j);
    if (k < j) return 1;
    return (k - j + 2) / 2 + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one operation; returns observed sum and latency
  task automatic run_op(input logic [15:0] w, input int k, input int j,
                        output int got, output int lat);
    @(negedge clk);
    start_i = 1'b1; word_i = w; k_i = 4'(k); j_i = 4'(j);
    lat = 0;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    got = int'(sum_o);
  endtask

  task automatic op_check(input string req, input logic [15:0] w, input int k, input int j);
    int got, lat;
    run_op(w, k, j, got, lat);
    check(req, got, ref_sum(w, k, j));
    check("R7 latency", lat, ref_lat(k, j));
  endtask

  initial begin
    int got, lat, held;
    seed_tmp = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sum", int'(sum_o), 0);
    check("R1 done", int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: worked slices
    op_check("R5 101", 16'b0000_0000_0000_0101, 2, 0);
    op_check("R5 1111", 16'b0000_0000_1111_0000, 7, 4);
    op_check("R5 011110", 16'b0000_0111_1000_0000, 11, 6);
    // R4: lone middle bit
    op_check("R4 single one", 16'h0100, 8, 8);
    op_check("R4 single zero", 16'hFEFF, 8, 8);
    op_check("R4 odd middle", 16'b0000_0000_0001_0000, 6, 2);
    // R3: pair needs both bits
    op_check("R3 half pair", 16'h8000, 15, 0);
    op_check("R3 adjacent", 16'h0018, 4, 3);
    // R10: maximum sum
    op_check("R10 all ones", 16'hFFFF, 15, 0);

    // R6: crossed indices
    run_op(16'hFFFF, 2, 9, got, lat);
    check("R6 sum", got, 0);
    check("R6 latency", lat, 1);

    // R8: done is a single pulse, sum holds
    run_op(16'hFFFF, 15, 0, got, lat);
    held = int'(sum_o);
    @(negedge clk);
    check("R8 done pulse", int'(done_o), 0);
    repeat (3) @(negedge clk);
    check("R8 sum held", int'(sum_o), held);

    // R9: start during a run is ignored
    @(negedge clk);
    start_i = 1'b1; word_i = 16'hFFFF; k_i = 4'd15; j_i = 4'd0;
    @(negedge clk);
    word_i = 16'h0000; k_i = 4'd3; j_i = 4'd1;
    lat = 1;
    repeat (2) begin @(negedge clk); lat++; end
    start_i = 1'b1; word_i = 16'h0001; k_i = 4'd0; j_i = 4'd5;
    @(negedge clk); lat++;
    start_i = 1'b0;
    while (!done_o && lat < 40) begin @(negedge clk); lat++; end
    check("R9 sum", int'(sum_o), 16);
    check("R9 latency", lat, ref_lat(15, 0));

    // R2: result after a large one starts fresh
    op_check("R2 fresh", 16'h0000, 15, 0);

    // sweep of every (k, j) with random words
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < 16; j++) begin
        op_check("R3 sweep", 16'($urandom), k, j);
      end
    end
    // random back-to-back operations
    for (int n = 0; n < 200; n++) begin
      op_check("R2 random", 16'($urandom), int'($urandom % 16), int'($urandom % 16));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule